// File: doc/BRIEF.md
# UDP receive classifier and dispatcher

This block sits between a 64-bit Ethernet receive datapath (frames already stripped of their FCS) and two consumers: a reconfiguration protocol engine and a general user application. Each frame arrives as 8-byte beats, first byte in the top lane. The block checks the destination MAC and IPv4 address against fixed local values. It sorts what remains into ARP or UDP traffic, and for UDP it decides the consumer from the destination port alone. The UDP payload is forwarded realigned to the beat boundary, with a byte count on every beat.

The block is a reply-only network presence. It answers ARP requests that ask for the local IPv4 address, and it stores the requester's MAC/IP pair as the peer for later traffic. On request it emits a short acknowledgement frame to that peer. This frame carries an IPv4 header with Don't Fragment set and a computed header checksum, and a UDP checksum of zero. Both kinds of transmitted frame are exactly 66 bytes long. The block never originates an ARP request and never reassembles fragments.

Top module: `netrx_dispatch`

## Requirements
- R1: After reset, eng_valid, app_valid, tx_valid and tx_busy are all low.
- R2: A frame whose destination MAC is neither LOCAL_MAC nor the all-ones broadcast address produces no payload output, no peer update and no transmitted frame.
- R3: An IPv4 frame (type 0x0800 at bytes 12-13) is dropped unless all of the following hold: byte 14 is 0x45; the protocol byte 23 is 17; destination IP bytes 30-33 equal LOCAL_IP; the more-fragments bit (bit 13 of bytes 20-21) is clear; the fragment offset (bits 12:0) is zero; and the destination MAC is not broadcast. Don't Fragment does not cause a drop.
- R4: An accepted UDP frame whose destination port (bytes 36-37) equals ENG_PORT_A (49000) or ENG_PORT_B (49001) is delivered on eng_valid. Every other port, such as 49200 and 49300, is delivered on app_valid.
- R5: The delivered payload is every frame byte from byte 42 to the frame end, in order. It is packed first byte in bits 63:56. pl_nbytes is 8 on every beat except the last, which carries 1 to 8 and raises pl_last.
- R6: An ARP frame (type 0x0806) with operation 1 and target IP (bytes 38-41) equal to LOCAL_IP stores its sender MAC (bytes 22-27) and sender IP (bytes 28-31) as the peer and triggers one reply. An ARP frame with another target IP or another operation does neither.
- R7: The ARP reply is sent to the peer. It has: source MAC LOCAL_MAC; type 0x0806; hardware type 1; protocol 0x0800; lengths 6 and 4; operation 2; sender LOCAL_MAC/LOCAL_IP; target peer MAC/IP; zero padding.
- R8: A pulse on ack_start while tx_busy is low sends an acknowledgement to the current peer. The frame has: type 0x0800; header byte 0x45; IP total length 52; ID 0; flags word 0x4000; TTL 64; protocol 17; source LOCAL_IP. The UDP part has source port ENG_PORT_A, destination port ack_dport, length 32 and checksum 0. It is followed by the 8 ack_data bytes and 16 zero bytes.
- R9: The transmitted IP header checksum is the ones'-complement of the ones'-complement sum of the ten 16-bit header words, taken with the checksum field as zero.
- R10: tx_busy is high while a frame is being sent or an ARP reply is waiting. An ARP reply requested during an acknowledgement is sent after it, and the acknowledgement keeps the peer it started with.
- R11: Every transmitted frame is 9 consecutive beats. The first eight beats have tx_nbytes 8. The ninth beat has tx_nbytes 2 and tx_last, which makes 66 bytes. tx_valid is low on the cycle after tx_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receive beat present |
| rx_data | input | 64 | Receive beat, first byte in bits 63:56 |
| rx_nbytes | input | 4 | Valid bytes in the beat (8 except on the last) |
| rx_last | input | 1 | Final beat of the frame |
| eng_valid | output | 1 | Payload beat for the reconfiguration engine |
| app_valid | output | 1 | Payload beat for the user application |
| pl_data | output | 64 | Realigned payload beat |
| pl_nbytes | output | 4 | Valid payload bytes in the beat |
| pl_last | output | 1 | Final payload beat |
| ack_start | input | 1 | Request one acknowledgement frame |
| ack_data | input | 64 | 8 acknowledgement payload bytes |
| ack_dport | input | 16 | UDP destination port of the acknowledgement |
| tx_busy | output | 1 | Transmitter occupied; ack_start is ignored |
| tx_valid | output | 1 | Transmit beat present |
| tx_data | output | 64 | Transmit beat, first byte in bits 63:56 |
| tx_nbytes | output | 4 | Valid bytes in the transmit beat |
| tx_last | output | 1 | Final transmit beat |

## Verification
The assertions assume several things about the inputs. Non-last receive beats carry 8 bytes, and the last beat carries 1 to 8. A frame holds at least 60 bytes. ack_start is raised only while tx_busy is low. The stimulus builds every frame from a byte array padded to 60 bytes, derives rx_nbytes from the true length, and pulses ack_start only after checking tx_busy. Random frames mix legal UDP traffic to all four named ports and a random port with corrupted addresses, header bytes, fragment fields and protocols. Directed lengths cover every last-beat byte count, and one directed case overlaps an ARP request with an acknowledgement.

// File: rtl/netd_pkg.sv
package netd_pkg;
    localparam int BEAT_W     = 64;
    localparam int NB_W       = 4;
    localparam int HDR_WORDS  = 10;
    localparam int TX_BEATS   = 9;
    localparam int TX_LAST_NB = 2;
    localparam int FRAME_W    = BEAT_W * TX_BEATS;
    localparam logic [15:0] ETYPE_IP4 = 16'h0800;
    localparam logic [15:0] ETYPE_ARP = 16'h0806;

    // ones'-complement checksum over a 20-byte IPv4 header (checksum field zero)
    function automatic logic [15:0] ones_fold(input logic [16*HDR_WORDS-1:0] hdr);
        logic [31:0] acc;
        acc = '0;
        for (int i = 0; i < HDR_WORDS; i++)
            acc = acc + {16'h0, hdr[16*HDR_WORDS-1-16*i -: 16]};
        acc = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
        acc = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
        return ~acc[15:0];
    endfunction
endpackage

// File: rtl/netrx_parse.sv
module netrx_parse
    import netd_pkg::*;
#(
    parameter logic [47:0] LOCAL_MAC  = 48'h02_00_00_00_00_2A,
    parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0A0A,
    parameter logic [15:0] ENG_PORT_A = 16'd49000,
    parameter logic [15:0] ENG_PORT_B = 16'd49001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BEAT_W-1:0] rx_data,
    input  logic [NB_W-1:0]   rx_nbytes,
    input  logic              rx_last,
    output logic              eng_valid,
    output logic              app_valid,
    output logic [BEAT_W-1:0] pl_data,
    output logic [NB_W-1:0]   pl_nbytes,
    output logic              pl_last,
    output logic              arp_hit,
    output logic [47:0]       peer_mac,
    output logic [31:0]       peer_ip
);
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              drop;
        logic              bc;
        logic              is_arp;
        logic              to_eng;
        logic [47:0]       sha;
        logic [31:0]       spa;
        logic [47:0]       hold;
        logic              flush;
        logic [NB_W-1:0]   flush_nb;
        logic [47:0]       peer_mac;
        logic [31:0]       peer_ip;
        logic              arp_hit;
        logic              eng_v;
        logic              app_v;
        logic [BEAT_W-1:0] pdata;
        logic [NB_W-1:0]   pnb;
        logic              plast;
    } rx_st_t;

    rx_st_t st_q, st_d;

    always_comb begin
        st_d         = st_q;
        st_d.eng_v   = 1'b0;
        st_d.app_v   = 1'b0;
        st_d.plast   = 1'b0;
        st_d.arp_hit = 1'b0;
        if (st_q.flush) begin
            st_d.flush = 1'b0;
            st_d.pdata = {st_q.hold, 16'h0};
            st_d.pnb   = st_q.flush_nb;
            st_d.plast = 1'b1;
            st_d.eng_v = st_q.to_eng;
            st_d.app_v = !st_q.to_eng;
        end
        if (rx_valid) begin
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            case (st_q.cnt)
                4'd0: begin
                    st_d.bc     = (rx_data[63:16] == 48'hFFFF_FFFF_FFFF);
                    st_d.drop   = !(rx_data[63:16] == LOCAL_MAC || st_d.bc);
                    st_d.is_arp = 1'b0;
                end
                4'd1: begin
                    if (rx_data[31:16] == ETYPE_ARP) st_d.is_arp = 1'b1;
                    else if (rx_data[31:16] != ETYPE_IP4 || rx_data[15:8] != 8'h45 || st_q.bc)
                        st_d.drop = 1'b1;
                end
                4'd2: begin
                    if (st_q.is_arp) begin
                        if (rx_data[31:16] != 16'h0001) st_d.drop = 1'b1;
                        st_d.sha[47:32] = rx_data[15:0];
                    end else if (rx_data[29] || rx_data[28:16] != '0 || rx_data[7:0] != 8'd17) begin
                        st_d.drop = 1'b1;
                    end
                end
                4'd3: begin
                    if (st_q.is_arp) begin
                        st_d.sha[31:0] = rx_data[63:32];
                        st_d.spa       = rx_data[31:0];
                    end else if (rx_data[15:0] != LOCAL_IP[31:16]) begin
                        st_d.drop = 1'b1;
                    end
                end
                4'd4: begin
                    if (st_q.is_arp) begin
                        if (rx_data[15:0] != LOCAL_IP[31:16]) st_d.drop = 1'b1;
                    end else begin
                        if (rx_data[63:48] != LOCAL_IP[15:0]) st_d.drop = 1'b1;
                        st_d.to_eng = (rx_data[31:16] == ENG_PORT_A) ||
                                      (rx_data[31:16] == ENG_PORT_B);
                    end
                end
                4'd5: begin
                    if (st_q.is_arp) begin
                        if (!st_q.drop && rx_data[63:48] == LOCAL_IP[15:0]) begin
                            st_d.peer_mac = st_q.sha;
                            st_d.peer_ip  = st_q.spa;
                            st_d.arp_hit  = 1'b1;
                        end
                        st_d.drop = 1'b1;
                    end else if (!st_q.drop) begin
                        st_d.hold = rx_data[47:0];
                        if (rx_last && rx_nbytes > 4'd2) begin
                            st_d.pdata = {rx_data[47:0], 16'h0};
                            st_d.pnb   = rx_nbytes - 4'd2;
                            st_d.plast = 1'b1;
                            st_d.eng_v = st_q.to_eng;
                            st_d.app_v = !st_q.to_eng;
                        end
                    end
                end
                default: begin
                    if (!st_q.drop && !st_q.is_arp) begin
                        st_d.pdata = {st_q.hold, rx_data[63:48]};
                        st_d.eng_v = st_q.to_eng;
                        st_d.app_v = !st_q.to_eng;
                        st_d.hold  = rx_data[47:0];
                        if (rx_last && rx_nbytes <= 4'd2) begin
                            st_d.pnb   = 4'd6 + rx_nbytes;
                            st_d.plast = 1'b1;
                        end else begin
                            st_d.pnb = 4'd8;
                            if (rx_last) begin
                                st_d.flush    = 1'b1;
                                st_d.flush_nb = rx_nbytes - 4'd2;
                            end
                        end
                    end
                end
            endcase
            if (rx_last) st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eng_valid = st_q.eng_v;
    assign app_valid = st_q.app_v;
    assign pl_data   = st_q.pdata;
    assign pl_nbytes = st_q.pnb;
    assign pl_last   = st_q.plast;
    assign arp_hit   = st_q.arp_hit;
    assign peer_mac  = st_q.peer_mac;
    assign peer_ip   = st_q.peer_ip;

    // R5: only the closing payload beat may be partial
    a_r5_full_inner: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.eng_v || st_q.app_v) && !st_q.plast) |-> (st_q.pnb == 4'd8));
    // R5: a pending remainder is always delivered next cycle as the final beat
    a_r5_flush_emits: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flush |=> ((st_q.eng_v || st_q.app_v) && st_q.plast && st_q.pnb != 4'd0));
    // R6: the stored peer only changes together with an accepted ARP request
    a_r6_peer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(st_q.peer_ip) || st_q.arp_hit));
endmodule

// File: rtl/nettx_build.sv
module nettx_build
    import netd_pkg::*;
#(
    parameter logic [47:0] LOCAL_MAC  = 48'h02_00_00_00_00_2A,
    parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0A0A,
    parameter logic [15:0] ENG_PORT_A = 16'd49000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arp_req,
    input  logic [47:0]       peer_mac,
    input  logic [31:0]       peer_ip,
    input  logic              ack_start,
    input  logic [BEAT_W-1:0] ack_data,
    input  logic [15:0]       ack_dport,
    output logic              tx_busy,
    output logic              tx_valid,
    output logic [BEAT_W-1:0] tx_data,
    output logic [NB_W-1:0]   tx_nbytes,
    output logic              tx_last
);
    localparam int IDX_W = $clog2(TX_BEATS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TX_BEATS - 1);
    localparam logic [15:0] IP_TOT_LEN  = 16'd52;
    localparam logic [15:0] UDP_LEN     = 16'd32;

    typedef struct packed {
        logic              busy;
        logic              kind_ack;
        logic [IDX_W-1:0]  idx;
        logic              arp_pend;
        logic [47:0]       dmac;
        logic [31:0]       dip;
        logic [BEAT_W-1:0] adata;
        logic [15:0]       aport;
        logic              v;
        logic [BEAT_W-1:0] data;
        logic [NB_W-1:0]   nb;
        logic              last;
    } tx_st_t;

    tx_st_t st_q, st_d;
    logic [16*HDR_WORDS-1:0] ip_hdr;
    logic [FRAME_W-1:0]      ack_frame, arp_frame, cur_frame;

    always_comb begin
        ip_hdr = {16'h4500, IP_TOT_LEN, 16'h0000, 16'h4000, 8'd64, 8'd17, 16'h0000,
                  LOCAL_IP, st_q.dip};
        ack_frame = {st_q.dmac, LOCAL_MAC, ETYPE_IP4,
                     ip_hdr[159:80], ones_fold(ip_hdr), ip_hdr[63:0],
                     ENG_PORT_A, st_q.aport, UDP_LEN, 16'h0000,
                     st_q.adata, 128'h0, 48'h0};
        arp_frame = {st_q.dmac, LOCAL_MAC, ETYPE_ARP,
                     16'h0001, ETYPE_IP4, 8'd6, 8'd4, 16'h0002,
                     LOCAL_MAC, LOCAL_IP, st_q.dmac, st_q.dip, 240'h0};
        cur_frame = st_q.kind_ack ? ack_frame : arp_frame;
    end

    always_comb begin
        st_d          = st_q;
        st_d.v        = 1'b0;
        st_d.last     = 1'b0;
        st_d.arp_pend = st_q.arp_pend | arp_req;
        if (st_q.busy) begin
            st_d.v    = 1'b1;
            st_d.data = cur_frame[FRAME_W-1-BEAT_W*int'(st_q.idx) -: BEAT_W];
            if (st_q.idx == LAST_IDX) begin
                st_d.nb   = NB_W'(TX_LAST_NB);
                st_d.last = 1'b1;
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.nb  = NB_W'(BEAT_W / 8);
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (ack_start && !st_q.arp_pend) begin
            st_d.busy     = 1'b1;
            st_d.kind_ack = 1'b1;
            st_d.dmac     = peer_mac;
            st_d.dip      = peer_ip;
            st_d.adata    = ack_data;
            st_d.aport    = ack_dport;
        end else if (st_q.arp_pend || arp_req) begin
            st_d.busy     = 1'b1;
            st_d.kind_ack = 1'b0;
            st_d.arp_pend = 1'b0;
            st_d.dmac     = peer_mac;
            st_d.dip      = peer_ip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_busy   = st_q.busy | st_q.arp_pend;
    assign tx_valid  = st_q.v;
    assign tx_data   = st_q.data;
    assign tx_nbytes = st_q.nb;
    assign tx_last   = st_q.last;

    // R11: a frame is emitted without gaps
    a_r11_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.v && !st_q.last) |=> st_q.v);
    // R11: frames are separated by an idle cycle
    a_r11_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.last |=> !st_q.v);
    // R11: byte counts are 8 on inner beats and 2 on the closing beat
    a_r11_beat_size: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v |-> (st_q.last ? (st_q.nb == 4'd2) : (st_q.nb == 4'd8)));
    // R10: a waiting ARP reply starts as soon as the transmitter is idle
    a_r10_pending_served: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.arp_pend && !st_q.busy) |=> (st_q.busy && !st_q.kind_ack));
endmodule

// File: rtl/netrx_dispatch.sv
module netrx_dispatch
    import netd_pkg::*;
#(
    parameter logic [47:0] LOCAL_MAC  = 48'h02_00_00_00_00_2A,
    parameter logic [31:0] LOCAL_IP   = 32'hC0A8_0A0A,
    parameter logic [15:0] ENG_PORT_A = 16'd49000,
    parameter logic [15:0] ENG_PORT_B = 16'd49001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BEAT_W-1:0] rx_data,
    input  logic [NB_W-1:0]   rx_nbytes,
    input  logic              rx_last,
    output logic              eng_valid,
    output logic              app_valid,
    output logic [BEAT_W-1:0] pl_data,
    output logic [NB_W-1:0]   pl_nbytes,
    output logic              pl_last,
    input  logic              ack_start,
    input  logic [BEAT_W-1:0] ack_data,
    input  logic [15:0]       ack_dport,
    output logic              tx_busy,
    output logic              tx_valid,
    output logic [BEAT_W-1:0] tx_data,
    output logic [NB_W-1:0]   tx_nbytes,
    output logic              tx_last
);
    logic        arp_hit;
    logic [47:0] peer_mac;
    logic [31:0] peer_ip;

    netrx_parse #(
        .LOCAL_MAC(LOCAL_MAC), .LOCAL_IP(LOCAL_IP),
        .ENG_PORT_A(ENG_PORT_A), .ENG_PORT_B(ENG_PORT_B)
    ) parse_i (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_nbytes(rx_nbytes), .rx_last(rx_last),
        .eng_valid(eng_valid), .app_valid(app_valid), .pl_data(pl_data),
        .pl_nbytes(pl_nbytes), .pl_last(pl_last),
        .arp_hit(arp_hit), .peer_mac(peer_mac), .peer_ip(peer_ip)
    );

    nettx_build #(
        .LOCAL_MAC(LOCAL_MAC), .LOCAL_IP(LOCAL_IP), .ENG_PORT_A(ENG_PORT_A)
    ) build_i (
        .clk(clk), .rst_n(rst_n),
        .arp_req(arp_hit), .peer_mac(peer_mac), .peer_ip(peer_ip),
        .ack_start(ack_start), .ack_data(ack_data), .ack_dport(ack_dport),
        .tx_busy(tx_busy), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_nbytes(tx_nbytes), .tx_last(tx_last)
    );

    // R4: a payload beat never goes to both consumers
    a_r4_single_consumer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_valid, app_valid}));
endmodule

// File: tb/netrx_dispatch_tb_top.sv
module netrx_dispatch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] MY_MAC  = 48'h02_00_00_00_00_2A;
    localparam logic [31:0] MY_IP   = 32'hC0A8_0A0A;
    localparam logic [47:0] H1_MAC  = 48'h00_1B_21_AA_BB_CC;
    localparam logic [31:0] H1_IP   = 32'hC0A8_0A01;
    localparam logic [47:0] H2_MAC  = 48'h00_1B_21_11_22_33;
    localparam logic [31:0] H2_IP   = 32'hC0A8_0A02;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_valid = 0, rx_last = 0, ack_start = 0;
    logic [63:0] rx_data = '0, ack_data = '0;
    logic [3:0] rx_nbytes = '0;
    logic [15:0] ack_dport = '0;
    logic eng_valid, app_valid, pl_last, tx_busy, tx_valid, tx_last;
    logic [63:0] pl_data, tx_data;
    logic [3:0] pl_nbytes, tx_nbytes;

    always #(CLK_PERIOD/2) clk = ~clk;

    netrx_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_nbytes(rx_nbytes), .rx_last(rx_last), .eng_valid(eng_valid),
        .app_valid(app_valid), .pl_data(pl_data), .pl_nbytes(pl_nbytes),
        .pl_last(pl_last), .ack_start(ack_start), .ack_data(ack_data),
        .ack_dport(ack_dport), .tx_busy(tx_busy), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_nbytes(tx_nbytes), .tx_last(tx_last)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] fb [0:2047];
    int flen;
    logic [7:0] eb [0:2047];
    logic [7:0] ab [0:2047];
    logic [7:0] tb [0:255];
    logic [7:0] xb [0:255];
    int ecnt = 0, efr = 0, acnt = 0, afr = 0, tcnt = 0, tfr = 0;

    always @(negedge clk) if (rst_n) begin
        if (eng_valid) begin
            for (int k = 0; k < int'(pl_nbytes); k++) begin
                if (ecnt < 2048) eb[ecnt] = pl_data[63-8*k -: 8];
                ecnt++;
            end
            if (pl_last) efr++;
        end
        if (app_valid) begin
            for (int k = 0; k < int'(pl_nbytes); k++) begin
                if (acnt < 2048) ab[acnt] = pl_data[63-8*k -: 8];
                acnt++;
            end
            if (pl_last) afr++;
        end
        if (tx_valid) begin
            for (int k = 0; k < int'(tx_nbytes); k++) begin
                if (tcnt < 256) tb[tcnt] = tx_data[63-8*k -: 8];
                tcnt++;
            end
            if (tx_last) tfr++;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit tox, input int off, input int n, input logic [63:0] v);
        for (int i = 0; i < n; i++) begin
            if (tox) xb[off+i] = v[8*(n-1-i) +: 8];
            else     fb[off+i] = v[8*(n-1-i) +: 8];
        end
    endtask

    task automatic clear_mon();
        ecnt = 0; efr = 0; acnt = 0; afr = 0; tcnt = 0; tfr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic build_ip(input logic [47:0] dmac, input logic [31:0] dip,
                            input logic [15:0] fragw, input logic [7:0] vihl,
                            input logic [7:0] proto, input logic [15:0] dport, input int plen);
        wr(0, 0, 6, 64'(dmac));  wr(0, 6, 6, 64'(H1_MAC)); wr(0, 12, 2, 64'h0800);
        wr(0, 14, 1, 64'(vihl)); wr(0, 15, 1, 0); wr(0, 16, 2, 64'(28 + plen));
        wr(0, 18, 2, 64'h1234); wr(0, 20, 2, 64'(fragw)); wr(0, 22, 1, 64);
        wr(0, 23, 1, 64'(proto)); wr(0, 24, 2, 0); wr(0, 26, 4, 64'(H1_IP));
        wr(0, 30, 4, 64'(dip)); wr(0, 34, 2, 64'd1234); wr(0, 36, 2, 64'(dport));
        wr(0, 38, 2, 64'(8 + plen)); wr(0, 40, 2, 0);
        for (int i = 0; i < plen; i++) fb[42+i] = 8'($urandom);
        flen = 42 + plen;
        while (flen < 60) begin fb[flen] = 8'h00; flen++; end
    endtask

    task automatic build_arp(input logic [47:0] dmac, input logic [47:0] smac,
                             input logic [31:0] sip, input logic [15:0] oper,
                             input logic [31:0] tpa);
        for (int i = 0; i < 60; i++) fb[i] = 8'h00;
        wr(0, 0, 6, 64'(dmac)); wr(0, 6, 6, 64'(smac)); wr(0, 12, 2, 64'h0806);
        wr(0, 14, 2, 64'h0001); wr(0, 16, 2, 64'h0800); wr(0, 18, 1, 6); wr(0, 19, 1, 4);
        wr(0, 20, 2, 64'(oper)); wr(0, 22, 6, 64'(smac)); wr(0, 28, 4, 64'(sip));
        wr(0, 38, 4, 64'(tpa));
        flen = 60;
    endtask

    task automatic send_frame();
        for (int b = 0; b < flen; b += 8) begin
            rx_valid = 1'b1;
            rx_data = '0;
            for (int k = 0; k < 8; k++)
                if (b + k < flen) rx_data[63-8*k -: 8] = fb[b+k];
            rx_nbytes = (flen - b >= 8) ? 4'd8 : 4'(flen - b);
            rx_last = (b + 8 >= flen);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic mk_arp(input int off, input logic [47:0] dmac, input logic [31:0] dip);
        for (int i = 0; i < 66; i++) xb[off+i] = 8'h00;
        wr(1, off, 6, 64'(dmac)); wr(1, off+6, 6, 64'(MY_MAC)); wr(1, off+12, 2, 64'h0806);
        wr(1, off+14, 2, 64'h0001); wr(1, off+16, 2, 64'h0800); wr(1, off+18, 1, 6);
        wr(1, off+19, 1, 4); wr(1, off+20, 2, 64'h0002); wr(1, off+22, 6, 64'(MY_MAC));
        wr(1, off+28, 4, 64'(MY_IP)); wr(1, off+32, 6, 64'(dmac)); wr(1, off+38, 4, 64'(dip));
    endtask

    task automatic mk_ack(input int off, input logic [47:0] dmac, input logic [31:0] dip,
                          input logic [63:0] d, input logic [15:0] dport);
        int sum;
        for (int i = 0; i < 66; i++) xb[off+i] = 8'h00;
        wr(1, off, 6, 64'(dmac)); wr(1, off+6, 6, 64'(MY_MAC)); wr(1, off+12, 2, 64'h0800);
        wr(1, off+14, 2, 64'h4500); wr(1, off+16, 2, 64'd52); wr(1, off+20, 2, 64'h4000);
        wr(1, off+22, 1, 64); wr(1, off+23, 1, 17); wr(1, off+26, 4, 64'(MY_IP));
        wr(1, off+30, 4, 64'(dip)); wr(1, off+34, 2, 64'd49000); wr(1, off+36, 2, 64'(dport));
        wr(1, off+38, 2, 64'd32); wr(1, off+42, 8, d);
        // R9: checksum over the header bytes, folded and inverted
        sum = 0;
        for (int i = 0; i < 20; i += 2) sum += {xb[off+14+i], xb[off+15+i]};
        while (sum > 32'hFFFF) sum = (sum & 32'hFFFF) + (sum >> 16);
        wr(1, off+24, 2, 64'(16'(~sum)));
    endtask

    task automatic cmp_tx(input int n, input int frames, input string tag);
        int bad, first;
        bad = 0; first = -1;
        chk(tfr == frames, {tag, " frame count"}, tfr, frames);
        chk(tcnt == n, {tag, " byte count (R11)"}, tcnt, n);
        for (int i = 0; i < n && i < 256; i++)
            if (tb[i] !== xb[i]) begin bad++; if (first < 0) first = i; end
        if (bad != 0)
            $display("  note: first tx byte mismatch at %0d: %02h vs %02h", first, tb[first], xb[first]);
        chk(bad == 0, {tag, " tx bytes mismatching"}, bad, 0);
    endtask

    task automatic pulse_ack(input logic [63:0] d, input logic [15:0] p);
        ack_data = d; ack_dport = p; ack_start = 1'b1;
        @(negedge clk);
        ack_start = 1'b0;
        chk(tx_busy == 1'b1, "R10 busy after ack_start", tx_busy, 1);
    endtask

    // UDP frame with expected routing; good=0 means it must be dropped
    task automatic run_udp(input logic [47:0] dmac, input logic [31:0] dip, input logic [15:0] fragw,
                           input logic [7:0] vihl, input logic [7:0] proto, input logic [15:0] dport,
                           input int plen, input bit good, input string tag);
        int n, bad;
        bit to_eng;
        build_ip(dmac, dip, fragw, vihl, proto, dport, plen);
        clear_mon();
        send_frame();
        idle(4);
        n = good ? flen - 42 : 0;
        to_eng = good && (dport == 16'd49000 || dport == 16'd49001);
        chk(ecnt == (to_eng ? n : 0) && efr == (to_eng ? 1 : 0), {tag, " R4 engine bytes"}, ecnt, to_eng ? n : 0);
        chk(acnt == ((good && !to_eng) ? n : 0) && afr == ((good && !to_eng) ? 1 : 0),
            {tag, " R4 app bytes"}, acnt, (good && !to_eng) ? n : 0);
        if (good) begin
            bad = 0;
            for (int i = 0; i < n; i++)
                if ((to_eng ? eb[i] : ab[i]) !== fb[42+i]) bad++;
            chk(bad == 0, {tag, " R5 payload bytes mismatching"}, bad, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R11 actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] ports [5];
        int sel, kind, plen;
        void'($urandom(32'd1234));
        ports[0] = 16'd49000; ports[1] = 16'd49001; ports[2] = 16'd49200; ports[3] = 16'd49300;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1: quiet after reset
        chk(!eng_valid && !app_valid, "R1 payload valid after reset", eng_valid | app_valid, 0);
        chk(!tx_valid && !tx_busy, "R1 tx idle after reset", tx_valid | tx_busy, 0);

        // R6/R7: broadcast ARP request for the local address
        build_arp(BCAST, H1_MAC, H1_IP, 16'h0001, MY_IP);
        clear_mon(); send_frame(); idle(20);
        mk_arp(0, H1_MAC, H1_IP);
        cmp_tx(66, 1, "R7 ARP reply");

        // R6: request for another address, and an ARP reply frame, are both ignored
        build_arp(BCAST, H2_MAC, H2_IP, 16'h0001, 32'hC0A8_0A63);
        clear_mon(); send_frame(); idle(20);
        chk(tfr == 0, "R6 ARP for foreign IP", tfr, 0);
        build_arp(MY_MAC, H2_MAC, H2_IP, 16'h0002, MY_IP);
        clear_mon(); send_frame(); idle(20);
        chk(tfr == 0, "R6 ARP operation 2", tfr, 0);

        // R2: unicast ARP to another MAC
        build_arp(48'h02_00_00_00_00_99, H2_MAC, H2_IP, 16'h0001, MY_IP);
        clear_mon(); send_frame(); idle(20);
        chk(tfr == 0, "R2 ARP to foreign MAC", tfr, 0);

        // R8/R9: acknowledgement to the stored peer (still host 1)
        clear_mon();
        pulse_ack(64'h0123_4567_89AB_CDEF, 16'd5555);
        idle(15);
        mk_ack(0, H1_MAC, H1_IP, 64'h0123_4567_89AB_CDEF, 16'd5555);
        cmp_tx(66, 1, "R8 ACK frame");
        chk(tx_busy == 1'b0, "R10 busy clears", tx_busy, 0);

        // R10: ARP request lands while an acknowledgement is in flight
        clear_mon();
        pulse_ack(64'hFEED_0000_0000_BEEF, 16'd49000);
        build_arp(BCAST, H2_MAC, H2_IP, 16'h0001, MY_IP);
        send_frame(); idle(30);
        mk_ack(0, H1_MAC, H1_IP, 64'hFEED_0000_0000_BEEF, 16'd49000);
        mk_arp(66, H2_MAC, H2_IP);
        cmp_tx(132, 2, "R10 ACK then deferred ARP");

        // R6: peer now host 2
        clear_mon();
        pulse_ack(64'h0000_0000_0000_0001, 16'd49001);
        idle(15);
        mk_ack(0, H2_MAC, H2_IP, 64'h0000_0000_0000_0001, 16'd49001);
        cmp_tx(66, 1, "R6 ACK to updated peer");

        // R5: every closing-beat size
        for (int l = 18; l <= 30; l++)
            run_udp(MY_MAC, MY_IP, 16'h0000, 8'h45, 8'd17, 16'd49200, l, 1'b1, "directed length");
        // R3: Don't Fragment alone is accepted
        run_udp(MY_MAC, MY_IP, 16'h4000, 8'h45, 8'd17, 16'd49000, 100, 1'b1, "R3 DF set");

        // random mix of good and corrupted UDP frames
        for (int f = 0; f < 80; f++) begin
            sel = $urandom % 5;
            ports[4] = 16'(1024 + $urandom % 40000);
            kind = $urandom % 12;
            plen = 1 + $urandom % 300;
            case (kind)
                0: run_udp(MY_MAC ^ 48'h1, MY_IP, 0, 8'h45, 17, ports[sel], plen, 0, "R2 foreign MAC");
                1: run_udp(MY_MAC, MY_IP, 0, 8'h46, 17, ports[sel], plen, 0, "R3 options");
                2: run_udp(MY_MAC, MY_IP, 16'h2000, 8'h45, 17, ports[sel], plen, 0, "R3 more-fragments");
                3: run_udp(MY_MAC, MY_IP, 16'h0010, 8'h45, 17, ports[sel], plen, 0, "R3 offset");
                4: run_udp(MY_MAC, MY_IP, 0, 8'h45, 6, ports[sel], plen, 0, "R3 protocol");
                5: run_udp(MY_MAC, MY_IP ^ 32'h100, 0, 8'h45, 17, ports[sel], plen, 0, "R3 foreign IP");
                6: run_udp(BCAST, MY_IP, 0, 8'h45, 17, ports[sel], plen, 0, "R3 broadcast IP");
                default: run_udp(MY_MAC, MY_IP, 16'h4000, 8'h45, 17, ports[sel], plen, 1, "random good");
            endcase
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule